// File: doc/BRIEF.md
# Two-Level Microprogram Sequencer

This block steps through microcode for a multicycle datapath. A control address register (CAR) indexes a first-level store of narrow microinstructions. Each microinstruction carries a next-address field, a condition select, a load-source select and a short pointer. The pointer indexes a second-level store that holds each distinct wide control word exactly once. That control word is the block's output towards the datapath.

On every clock the CAR either counts up by one or loads a new address. A condition multiplexer makes the choice. It picks among constant false, constant true and four status flags. When a load happens, the new address is either the next-address field of the current microinstruction or the opcode supplied from the instruction register. This is how instruction dispatch is done.

Both stores are read-only. Their contents come from constant functions inside the RTL. The first-level depth follows the CAR width, the second-level depth follows the pointer width, and the control word width is a parameter of its own.

Top module: `useq_two_level`

## Requirements
- R1: While `rst_n` is low, `car_o` is 0 and `ctrl_word_o` is 0. The first clock after release starts from address 0.
- R2: The 3-bit condition select gives "take" as follows: 0 is false, 1 is true, 2 is `flags_i[0]` (zero), 3 is `flags_i[1]` (negative), 4 is `flags_i[2]` (carry), 5 is `flags_i[3]` (overflow), and 6 and 7 are false. Flags that are not selected have no effect.
- R3: When "take" is false, the CAR increments by one modulo 2^CAR_W, so the all-ones address is followed by 0.
- R4: When "take" is true and the source select is 0, the CAR loads the next-address field of the current microinstruction.
- R5: When "take" is true and the source select is 1, the CAR loads `opcode_i`.
- R6: `ctrl_word_o` is registered. After each clock it equals the second-level word addressed by the pointer of the microinstruction at which the CAR stood before that clock.
- R7: The first-level entry at address a holds the following fields. The next-address field is (3a+5) mod 2^CAR_W. The condition select is a[2:0]. The source select is a[3]. The pointer is a mod 2^PTR_W.
- R8: Second-level word p, bit i, equals bit (i mod PTR_W) of p, inverted when floor(i/PTR_W) is odd. With the default widths this gives {~p,p,~p,p}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | CAR_W | Opcode from the instruction register, used as the dispatch address |
| flags_i | input | 4 | Status flags: bit 0 zero, bit 1 negative, bit 2 carry, bit 3 overflow |
| car_o | output | CAR_W | Current control address |
| ctrl_word_o | output | CW_W | Registered control word for the datapath |

## Verification
A wrong CAR value shows up on `car_o` at the very next edge. One clock later it also shows up on `ctrl_word_o`, because the pointer taken from the wrong entry picks a different word. A wrong condition decode or source decode shows up as a path that diverges at the first microinstruction that selects the faulty case. For that reason, every condition code and both load sources are reached by dispatching straight to a chosen address. Incrementing past the all-ones address is tested directly, because a carry error there would otherwise stay hidden.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int COND_W = 3;
    localparam int FLAG_W = 4;

    localparam int FLAG_Z = 0;
    localparam int FLAG_N = 1;
    localparam int FLAG_C = 2;
    localparam int FLAG_V = 3;

    typedef enum logic [COND_W-1:0] {
        COND_NEVER  = 3'd0,
        COND_ALWAYS = 3'd1,
        COND_ZERO   = 3'd2,
        COND_NEG    = 3'd3,
        COND_CARRY  = 3'd4,
        COND_OVF    = 3'd5
    } cond_sel_e;
endpackage

// File: rtl/useq_l1_store.sv
module useq_l1_store
    import useq_pkg::*;
#(
    parameter int CAR_W = 8,
    parameter int PTR_W = 4
) (
    input  logic [CAR_W-1:0] addr_i,
    output logic [CAR_W-1:0] next_addr_o,
    output logic [COND_W-1:0] cond_sel_o,
    output logic             src_sel_o,
    output logic [PTR_W-1:0] ptr_o
);
    localparam int ENTRY_W = CAR_W + COND_W + 1 + PTR_W;
    localparam int DEPTH   = 1 << CAR_W;

    // R7: entry a = {(3a+5), a[2:0], a[3], a mod 2^PTR_W}
    function automatic logic [ENTRY_W-1:0] entry_for(input int a);
        logic [CAR_W-1:0]  nxt;
        logic [COND_W-1:0] cnd;
        logic              src;
        logic [PTR_W-1:0]  ptr;
        nxt = CAR_W'(3 * a + 5);
        cnd = COND_W'(a);
        src = 1'((a >> 3) & 1);
        ptr = PTR_W'(a);
        return {nxt, cnd, src, ptr};
    endfunction

    logic [ENTRY_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign rom[g] = entry_for(g);
    end

    logic [ENTRY_W-1:0] entry;
    assign entry = rom[addr_i];

    assign next_addr_o = entry[ENTRY_W-1 -: CAR_W];
    assign cond_sel_o  = entry[PTR_W+1 +: COND_W];
    assign src_sel_o   = entry[PTR_W];
    assign ptr_o       = entry[PTR_W-1:0];
endmodule

// File: rtl/useq_l2_store.sv
module useq_l2_store #(
    parameter int PTR_W = 4,
    parameter int CW_W  = 16
) (
    input  logic [PTR_W-1:0] ptr_i,
    output logic [CW_W-1:0]  word_o
);
    localparam int DEPTH = 1 << PTR_W;

    // R8: bit i = p[i mod PTR_W] inverted on odd chunks
    function automatic logic [CW_W-1:0] word_for(input int p);
        logic [PTR_W-1:0] pb;
        logic [CW_W-1:0]  w;
        pb = PTR_W'(p);
        for (int i = 0; i < CW_W; i++) begin
            w[i] = pb[i % PTR_W] ^ (((i / PTR_W) % 2) == 1);
        end
        return w;
    endfunction

    logic [CW_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign rom[g] = word_for(g);
    end

    assign word_o = rom[ptr_i];
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] sel_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              take_o
);
    always_comb begin
        unique case (sel_i)
            COND_NEVER:  take_o = 1'b0;
            COND_ALWAYS: take_o = 1'b1;
            COND_ZERO:   take_o = flags_i[FLAG_Z];
            COND_NEG:    take_o = flags_i[FLAG_N];
            COND_CARRY:  take_o = flags_i[FLAG_C];
            COND_OVF:    take_o = flags_i[FLAG_V];
            default:     take_o = 1'b0;
        endcase
    end

    a_r2_reserved_never_take : assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i > COND_W'(5)) |-> !take_o);
    a_r2_const_codes : assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == COND_W'(1)) || (sel_i == COND_W'(0)) |-> take_o == sel_i[0]);
endmodule

// File: rtl/useq_car_next.sv
module useq_car_next #(
    parameter int CAR_W = 8
) (
    input  logic [CAR_W-1:0] car_i,
    input  logic             take_i,
    input  logic             src_i,
    input  logic [CAR_W-1:0] field_i,
    input  logic [CAR_W-1:0] opcode_i,
    output logic [CAR_W-1:0] car_o
);
    logic [CAR_W-1:0] load_addr;

    always_comb begin
        load_addr = src_i ? opcode_i : field_i;
        car_o     = take_i ? load_addr : car_i + CAR_W'(1);
    end
endmodule

// File: rtl/useq_two_level.sv
module useq_two_level
    import useq_pkg::*;
#(
    parameter int CAR_W = 8,
    parameter int PTR_W = 4,
    parameter int CW_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAR_W-1:0] opcode_i,
    input  logic [3:0]       flags_i,
    output logic [CAR_W-1:0] car_o,
    output logic [CW_W-1:0]  ctrl_word_o
);
    typedef struct packed {
        logic [CAR_W-1:0] car;
        logic [CW_W-1:0]  cw;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [CAR_W-1:0]  field;
    logic [COND_W-1:0] cond_sel;
    logic              src_sel;
    logic [PTR_W-1:0]  ptr;
    logic              take;
    logic [CAR_W-1:0]  car_nxt;
    logic [CW_W-1:0]   word;

    useq_l1_store #(.CAR_W(CAR_W), .PTR_W(PTR_W)) u_l1 (
        .addr_i      (st_q.car),
        .next_addr_o (field),
        .cond_sel_o  (cond_sel),
        .src_sel_o   (src_sel),
        .ptr_o       (ptr)
    );

    useq_cond_mux u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (cond_sel),
        .flags_i (flags_i),
        .take_o  (take)
    );

    useq_car_next #(.CAR_W(CAR_W)) u_next (
        .car_i    (st_q.car),
        .take_i   (take),
        .src_i    (src_sel),
        .field_i  (field),
        .opcode_i (opcode_i),
        .car_o    (car_nxt)
    );

    useq_l2_store #(.PTR_W(PTR_W), .CW_W(CW_W)) u_l2 (
        .ptr_i  (ptr),
        .word_o (word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.car = car_nxt;
        st_d.cw  = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign car_o       = st_q.car;
    assign ctrl_word_o = st_q.cw;

    a_r3_increment : assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> st_q.car == $past(st_q.car) + CAR_W'(1));
    a_r3_wrap_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (!take && st_q.car == '1) |=> st_q.car == '0);
    a_r4_load_field : assert property (@(posedge clk) disable iff (!rst_n)
        (take && !src_sel) |=> st_q.car == $past(field));
    a_r5_load_opcode : assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_sel) |=> st_q.car == $past(opcode_i));
    a_r6_word_lag : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.cw == $past(word));
endmodule

// File: tb/useq_two_level_tb.sv
module useq_two_level_tb;
    localparam int CAR_W = 8;
    localparam int PTR_W = 4;
    localparam int CW_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CAR_W-1:0] opcode_i = '0;
    logic [3:0]       flags_i = '0;
    logic [CAR_W-1:0] car_o;
    logic [CW_W-1:0]  ctrl_word_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    useq_two_level #(.CAR_W(CAR_W), .PTR_W(PTR_W), .CW_W(CW_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .opcode_i    (opcode_i),
        .flags_i     (flags_i),
        .car_o       (car_o),
        .ctrl_word_o (ctrl_word_o)
    );

    // Reference model written from R2, R7, R8
    function automatic logic [CAR_W-1:0] m_field(input logic [CAR_W-1:0] a);
        return CAR_W'(3 * int'(a) + 5);
    endfunction
    function automatic logic m_take(input logic [CAR_W-1:0] a, input logic [3:0] f);
        case (a[2:0])
            3'd1: return 1'b1;
            3'd2: return f[0];
            3'd3: return f[1];
            3'd4: return f[2];
            3'd5: return f[3];
            default: return 1'b0;
        endcase
    endfunction
    function automatic logic [CW_W-1:0] m_word(input logic [CAR_W-1:0] a);
        logic [PTR_W-1:0] p;
        p = a[PTR_W-1:0];
        return {~p, p, ~p, p};
    endfunction
    function automatic logic [CAR_W-1:0] m_next(input logic [CAR_W-1:0] a,
                                                 input logic [3:0] f,
                                                 input logic [CAR_W-1:0] op);
        if (!m_take(a, f)) return a + CAR_W'(1);
        return a[3] ? op : m_field(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] f, input logic [CAR_W-1:0] op);
        flags_i  = f;
        opcode_i = op;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // path 0 -> 1 -> 8 -> 9, then the dispatch at 9 loads op (R5)
    task automatic jump_to(input logic [CAR_W-1:0] op);
        do_reset();
        step(4'h0, 8'h00);
        step(4'h0, 8'h00);
        step(4'h0, 8'h00);
        step(4'h0, op);
        check(car_o == op, "R5 dispatch", 32'(car_o), 32'(op));
    endtask

    // {flags, opcode}
    localparam logic [11:0] VEC [16] = '{
        12'h0_00, 12'hF_30, 12'h1_47, 12'h2_9C, 12'h4_21, 12'h8_A5,
        12'h3_10, 12'hC_FE, 12'h5_02, 12'hA_7B, 12'h6_EE, 12'h9_01,
        12'hF_C3, 12'h0_5A, 12'h7_88, 12'hE_33
    };

    initial begin
        logic [CAR_W-1:0] exp_car;
        logic [CAR_W-1:0] prev;

        // R1 reset state
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(car_o == 0, "R1 car reset", 32'(car_o), 0);
        check(ctrl_word_o == 0, "R1 word reset", 32'(ctrl_word_o), 0);
        rst_n = 1'b1;

        // vector walk from address 0 (R2 R3 R4 R5 R6 R7 R8)
        exp_car = '0;
        for (int k = 0; k < 16; k++) begin
            prev    = exp_car;
            exp_car = m_next(prev, VEC[k][11:8], VEC[k][7:0]);
            step(VEC[k][11:8], VEC[k][7:0]);
            check(car_o == exp_car, "R7 walk car", 32'(car_o), 32'(exp_car));
            check(ctrl_word_o == m_word(prev), "R8 walk word",
                  32'(ctrl_word_o), 32'(m_word(prev)));
        end

        // R6 word after dispatch is that of address 9
        jump_to(8'h02);
        check(ctrl_word_o == 16'h6969, "R6 lag", 32'(ctrl_word_o), 32'h6969);
        step(4'hE, 8'h00);
        check(car_o == 8'h03, "R2 zero clear", 32'(car_o), 32'h03);
        jump_to(8'h02);
        step(4'h1, 8'h00);
        check(car_o == 8'h0B, "R4 zero set", 32'(car_o), 32'h0B);

        jump_to(8'h03);
        step(4'h2, 8'h00);
        check(car_o == 8'h0E, "R2 negative set", 32'(car_o), 32'h0E);
        jump_to(8'h03);
        step(4'hD, 8'h00);
        check(car_o == 8'h04, "R2 negative clear", 32'(car_o), 32'h04);

        jump_to(8'h04);
        step(4'h4, 8'h00);
        check(car_o == 8'h11, "R2 carry set", 32'(car_o), 32'h11);
        jump_to(8'h04);
        step(4'hB, 8'h00);
        check(car_o == 8'h05, "R2 carry clear", 32'(car_o), 32'h05);

        jump_to(8'h05);
        step(4'h8, 8'h00);
        check(car_o == 8'h14, "R2 overflow set", 32'(car_o), 32'h14);
        jump_to(8'h05);
        step(4'h7, 8'h00);
        check(car_o == 8'h06, "R2 overflow clear", 32'(car_o), 32'h06);

        // reserved codes and constant false ignore all flags
        jump_to(8'h06);
        step(4'hF, 8'hAA);
        check(car_o == 8'h07, "R2 code6", 32'(car_o), 32'h07);
        jump_to(8'h07);
        step(4'hF, 8'hAA);
        check(car_o == 8'h08, "R2 code7", 32'(car_o), 32'h08);
        jump_to(8'h10);
        step(4'hF, 8'hAA);
        check(car_o == 8'h11, "R3 const false", 32'(car_o), 32'h11);
        step(4'h0, 8'hAA);
        check(car_o == 8'h38, "R4 const true", 32'(car_o), 32'h38);

        // conditional dispatch through opcode
        jump_to(8'h0A);
        step(4'h1, 8'h55);
        check(car_o == 8'h55, "R5 opcode load", 32'(car_o), 32'h55);
        jump_to(8'h0A);
        step(4'hE, 8'h55);
        check(car_o == 8'h0B, "R5 opcode skip", 32'(car_o), 32'h0B);

        // R3 wrap past all ones
        jump_to(8'hFF);
        step(4'hF, 8'h12);
        check(car_o == 8'h00, "R3 wrap", 32'(car_o), 0);
        check(ctrl_word_o == 16'h0F0F, "R6 wrap word", 32'(ctrl_word_o), 32'h0F0F);

        // R1 reset mid-run
        rst_n = 1'b0;
        #2;
        check(car_o == 0, "R1 async car", 32'(car_o), 0);
        check(ctrl_word_o == 0, "R1 async word", 32'(ctrl_word_o), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule